// File: doc/BRIEF.md
# Inverted-Polarity Level Interrupt Controller

This block gathers up to 32 level-held interrupt requests from peripherals and presents them to a host CPU through a small 32-bit memory-mapped register window. Each source is sampled on every clock. The state appears in three registers, and all of them use inverted polarity: a 0 bit means pending or enabled, and a 1 bit means idle or disabled. One register shows the raw pending lines, including masked ones. One holds the enable mask. The third shows only those requests that are both pending and enabled.

Sources are level-held, so no register bit is ever cleared by a write. Software acknowledges a source by masking it: a read-modify-write of the mask register sets that source's bit. The peripheral later drops its line, and software unmasks the source again. A single combined interrupt line goes to the CPU. A side output gives the index of the lowest-numbered active, enabled source, together with a valid flag. Two words of read-only identification bytes sit at the bottom of the window.

Source bits 0 and 1 belong to internal functions. No peripheral drives them, so they always read as idle.

Top module: `irq_lvl_ctrl`

## Requirements
- R1: Full-address decode, word accesses only. Request register at 0x1000, mask register at 0x1004, raw pending register at 0x1008. Any other address, including a misaligned address inside the block, reads as 0x00000000.
- R2: Inverted polarity in every register. In the raw and request registers, bit n = 0 means source n is pending. In the mask register, bit n = 0 means source n is enabled.
- R3: On each clock edge the raw pending register takes the bitwise inverse of `src_lvl`, so it changes one edge after an input change. Masked sources are included. Bits 0 and 1 always read 1.
- R4: The request register equals the bitwise OR of the raw pending register and the mask register.
- R5: After reset the mask register reads 0xFFFFFFFF, the raw pending register reads 0xFFFFFFFF, and `cpu_irq` is 0.
- R6: A write to 0x1004 stores all 32 bits of `bus_wdata` into the mask at the next clock edge. A write to any other address changes no state.
- R7: A source stays pending for as long as its line is held high, even after a write of zeros to the raw or request address. It reads idle one edge after its line drops.
- R8: `cpu_irq` is 1 exactly when the request register holds at least one 0 bit. It follows the registered state, so it changes at the clock edge after an input change or after a mask write.
- R9: `irq_idx` is the position of the lowest 0 bit in the request register, and `irq_idx_vld` equals `cpu_irq`. When no bit is 0, `irq_idx` is 0.
- R10: A word read at 0x0 returns identification bytes 0..3, and a read at 0x4 returns bytes 4..7. Byte k sits in bits [8(k mod 4)+7 : 8(k mod 4)]. These words are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Level request lines, active high |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| cpu_irq | output | 1 | Combined interrupt to the CPU, active high |
| irq_idx | output | 5 | Lowest active enabled source |
| irq_idx_vld | output | 1 | irq_idx is meaningful |

## Verification
The embedded assertions check the following on every cycle:
- a fully set mask keeps `cpu_irq` low;
- all-idle inputs drop the interrupt one edge later;
- writes outside the mask address leave the mask unchanged;
- the reported index is a 0 bit with no 0 bit below it, and is never one of the two internal sources;
- the valid flag agrees with the combined output.

The register offsets, the identification bytes, the reset values and the exact cycle at which a change becomes visible can be shown only by the bench's scenarios. The same holds for the OR relation between the raw, mask and request registers over many patterns, and for the fact that writes to the status addresses never clear a held level.

// File: rtl/irq_lvl_ctrl.sv
module irq_lvl_ctrl #(
  parameter int              ADDR_W   = 16,
  parameter int              NSRC     = 32,
  parameter logic [63:0]     ID_BYTES = 64'h3130_5643_5249_5141,
  parameter logic [15:0]     BLK_OFS  = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cpu_irq,
  output logic [$clog2(NSRC)-1:0] irq_idx,
  output logic              irq_idx_vld
);
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [NSRC-1:0]   INTERNAL = NSRC'(3);
  localparam logic [ADDR_W-1:0] REQ_A = ADDR_W'(BLK_OFS);
  localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(BLK_OFS) + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] RAW_A = ADDR_W'(BLK_OFS) + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ID0_A = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ID1_A = ADDR_W'(4);

  logic [NSRC-1:0] pend_q, mask_q, req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= '1;
      mask_q <= '1;
    end else begin
      pend_q <= ~(src_lvl & ~INTERNAL);
      if (bus_sel && bus_wr && bus_addr == MSK_A)
        mask_q <= bus_wdata[NSRC-1:0];
    end

  assign req     = pend_q | mask_q;
  assign cpu_irq = ~&req;

  always_comb begin
    irq_idx     = '0;
    irq_idx_vld = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (!req[i]) begin
        irq_idx     = IDX_W'(i);
        irq_idx_vld = 1'b1;
      end
  end

  always_comb
    case (bus_addr)
      REQ_A:   bus_rdata = 32'(req);
      MSK_A:   bus_rdata = 32'(mask_q);
      RAW_A:   bus_rdata = 32'(pend_q);
      ID0_A:   bus_rdata = ID_BYTES[31:0];
      ID1_A:   bus_rdata = ID_BYTES[63:32];
      default: bus_rdata = 32'h0;
    endcase

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !cpu_irq);  // R8
  AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (src_lvl == '0) |=> !cpu_irq);  // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr != MSK_A) |=> $stable(mask_q));  // R6
  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_idx_vld |-> (!req[irq_idx] && ((~req & ((NSRC'(1) << irq_idx) - NSRC'(1))) == '0)));  // R9
  AST_IDX_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_idx_vld == cpu_irq);  // R9
  AST_NO_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (irq_idx >= IDX_W'(2)));  // R3
endmodule

// File: tb/irq_lvl_ctrl_tb.sv
`timescale 1ns/1ps
module irq_lvl_ctrl_tb_top;
  localparam logic [63:0] ID = 64'h3130_5643_5249_5141;

  logic        clk = 0, rst_n = 0;
  logic [31:0] src_lvl = '0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cpu_irq, irq_idx_vld;
  logic [4:0]  irq_idx;
  int          nchk = 0, nfail = 0;
  bit          done = 0;
  logic [31:0] mask_m = '1;

  always #2.5 clk = ~clk;

  irq_lvl_ctrl #(.ID_BYTES(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .irq_idx(irq_idx),
    .irq_idx_vld(irq_idx_vld));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%08h expected=%08h", r, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a == 16'h1004) mask_m = d;
  endtask

  function automatic logic [31:0] lowz(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (!v[i]) return 32'(i);
    return 0;
  endfunction

  task automatic check_state(string tag);
    logic [31:0] raw_e, req_e, d;
    raw_e = ~(src_lvl & ~32'h3);
    req_e = raw_e | mask_m;
    rd(16'h1008, d); chk({tag, " R3 raw"}, d, raw_e);
    rd(16'h1000, d); chk({tag, " R4 req"}, d, req_e);
    chk({tag, " R8 irq"}, 32'(cpu_irq), 32'(req_e != '1));
    chk({tag, " R9 idx"}, 32'(irq_idx), lowz(req_e));
    chk({tag, " R9 vld"}, 32'(irq_idx_vld), 32'(req_e != '1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(16'h1004, d); chk("R5 mask reset", d, 32'hFFFF_FFFF);
    rd(16'h1008, d); chk("R5 raw reset", d, 32'hFFFF_FFFF);
    chk("R5 irq reset", 32'(cpu_irq), 0);
    rd(16'h0000, d); chk("R10 id word0", d, ID[31:0]);
    rd(16'h0004, d); chk("R10 id word1", d, ID[63:32]);
    wr(16'h0000, 32'h0); wr(16'h0004, 32'h0);
    rd(16'h0000, d); chk("R10 id read-only", d, ID[31:0]);
    rd(16'h1010, d); chk("R1 unmapped", d, 0);
    rd(16'h1002, d); chk("R1 misaligned", d, 0);
    rd(16'h2004, d); chk("R1 alias", d, 0);
    // R1 R2 R3: single sources with everything enabled
    wr(16'h1004, 32'h0);
    rd(16'h1004, d); chk("R6 mask write", d, 32'h0);
    for (int s = 0; s < 32; s++) begin
      src_lvl = 32'd1 << s;
      @(negedge clk);
      check_state("R2 single");
    end
    // R8 timing: change visible only after the next edge
    src_lvl = '0; @(negedge clk);
    src_lvl = 32'h0000_0100; #0.5;
    chk("R8 before edge", 32'(cpu_irq), 0);
    @(negedge clk);
    chk("R8 after edge", 32'(cpu_irq), 1);
    // R7: held level survives writes to status addresses
    wr(16'h1008, 32'h0); wr(16'h1000, 32'h0);
    rd(16'h1008, d); chk("R7 held", d, 32'hFFFF_FEFF);
    rd(16'h1004, d); chk("R6 status write ignored", d, 32'h0);
    src_lvl = '0; @(negedge clk);
    rd(16'h1008, d); chk("R7 dropped", d, 32'hFFFF_FFFF);
    // R4 R9: all asserted, one source enabled at a time
    src_lvl = '1;
    for (int s = 0; s < 32; s++) begin
      wr(16'h1004, ~(32'd1 << s));
      check_state("R9 one-enabled");
    end
    // R6 mask write gating of irq
    wr(16'h1004, 32'hFFFF_FFFF);
    chk("R6 all masked", 32'(cpu_irq), 0);
    // priority patterns
    lf = 32'hACE1_2345;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      src_lvl = lf & {lf[15:0], lf[31:16]};
      wr(16'h1004, lf ^ 32'h5A5A_0F0F | (32'd1 << (k % 32)));
      check_state("R9 pattern");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule